// File: doc/BRIEF.md
# Single-Precision Reciprocal Square-Root Estimator

This unit takes one single-precision operand and returns an estimate of 1/sqrt(x) that is accurate to 8 bits, together with invalid, divide-by-zero and input-denormal flags. NaNs, zeros, negative operands and infinities are resolved straight away. Every other operand, including a denormal one that is not flushed, is normalised. Its mantissa is then scaled into a 9-bit integer whose form depends on the parity of the exponent. A serial integer search runs on that integer to produce the 8-bit estimate field.

A request is launched with a one-cycle `start` while the unit is idle. The unit raises `busy` until the work is finished and pulses `done` for exactly one cycle when `result` and the flags are fresh. These outputs then hold until the next accepted request completes. A `start` that arrives while `busy` is high is dropped.

The control is a three-state machine. ST_IDLE waits for `start`. ST_IDLE goes to ST_REPORT when the operand is a special case (transition "resolve"). ST_IDLE goes to ST_SEARCH when the operand needs the estimate (transition "launch"). ST_SEARCH stays in ST_SEARCH while the search bound is still too small (transition "step"). ST_SEARCH goes to ST_REPORT once the bound is found (transition "settle"). ST_REPORT always goes to ST_IDLE (transition "retire").

Top module: `rsqrt_estimate_unit`

## Requirements
- R1: While reset is applied and right after it, `busy`, `done`, `result` and all three flags are 0.
- R2: `start` is accepted only in the idle state, and a `start` seen while `busy` is high has no effect. Latency is counted in clock edges after the accepting edge:
  - A special operand raises `done` after edge 1.
  - A searched operand raises `done` after edge (bfinal-512)+2, where bfinal is the final search bound from R10.
  - `done` is high for one cycle, and `busy` is high from the accepting edge up to and including the `done` cycle.
- R3: A NaN operand has exponent 0xFF and a nonzero fraction. A signalling NaN has fraction bit 22 clear: it sets invalid and returns the operand with bit 22 set. A quiet NaN is returned unchanged with no flag. With `dnan_en` high, any NaN returns 0x7FC00000, and a signalling NaN still sets invalid.
- R4: A zero operand sets divide-by-zero and returns an infinity carrying the operand's sign (0x7F800000 or 0xFF800000).
- R5: Any other operand with sign bit 1, including negative infinity, sets invalid and returns 0x7FC00000.
- R6: Positive infinity returns 0x00000000 with no flag set.
- R7: With `flush_en` high, a denormal operand (exponent 0, fraction nonzero) sets input-denormal and is then treated as a zero of the same sign (R4). With `flush_en` low, input-denormal is never set.
- R8: A denormal operand that is not flushed is normalised:
  - Its fraction is shifted left by the count z of zeros above its leading one.
  - The leading one is dropped and the fraction is shifted once more.
  - The effective exponent becomes -z.
- R9: An odd effective exponent gives a scaled input of 128 plus the top 7 fraction bits. An even one gives 256 plus the top 8 fraction bits.
- R10: The estimate is computed from the scaled input a.
  - If a < 256, a' = 2a+1. Otherwise a' = (2*floor(a/2)+1)*2.
  - The bound b starts at 512 and grows by one while a'*(b+1)^2 < 2^28. The final value is bfinal.
  - The estimate is (bfinal+1)/2 and lies in 256..511.
- R11: A searched result has the following fields:
  - bit 31 is 0;
  - bits 30:23 hold (380 - effective exponent)/2;
  - bits 22:15 hold the low 8 bits of the estimate;
  - bits 14:0 are zero. The flags are all 0.
- R12: `result` and the flags change only on the cycle in which `done` is high, and hold their value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, one cycle, honoured only when idle |
| operand | input | 32 | Single-precision operand |
| flush_en | input | 1 | Treat denormal operands as zero |
| dnan_en | input | 1 | Return the default NaN for every NaN operand |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Estimate or special-case value |
| flag_invalid | output | 1 | Invalid-operation flag of the last request |
| flag_divzero | output | 1 | Divide-by-zero flag of the last request |
| flag_denorm | output | 1 | Input-denormal flag of the last request |

## Verification
The format widths, the search start and the 2^28 limit are fixed package constants, so the bench builds the unit as it stands, with no override. Its operands are chosen to reach both ends of the search:
- a' = 257 runs the longest search, about 511 steps;
- a' = 1022 settles on the first test;
- both parity forms of the scaled input are covered;
- denormals with the largest and smallest normalising shift are covered, flushed and unflushed.

A reference model in the bench predicts `busy` and `done` for every cycle of each request. It also injects a `start` in the middle of a search to confirm that the request is dropped.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
    localparam int WORD_W     = 32;
    localparam int EXP_W      = 8;
    localparam int FRAC_W     = 23;
    localparam int EST_W      = 8;
    localparam int SCALE_W    = EST_W + 1;
    localparam int DBL_W      = SCALE_W + 1;
    localparam int BOUND_W    = SCALE_W + 2;
    localparam int EXPE_W     = EXP_W + 3;
    localparam int LZ_W       = $clog2(FRAC_W + 1);
    localparam int PROD_W     = 32;
    localparam int PAD_W      = FRAC_W - EST_W;
    localparam logic [BOUND_W-1:0] B_START = BOUND_W'(512);
    localparam logic [PROD_W-1:0]  LIMIT   = PROD_W'(1) << 28;
    localparam int EXP_OFFSET = 380;
    localparam logic [EXP_W-1:0]  EXP_ONES = '1;
    localparam logic [WORD_W-1:0] DEF_NAN  = 32'h7FC0_0000;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_REPORT = 2'd2
    } rsq_state_e;
endpackage

// File: rtl/rsq_classify.sv
module rsq_classify
    import rsq_pkg::*;
(
    input  logic [WORD_W-1:0]       operand,
    input  logic                    flush_en,
    input  logic                    dnan_en,
    output logic                    is_special,
    output logic [WORD_W-1:0]       spec_result,
    output logic                    spec_inv,
    output logic                    spec_dz,
    output logic                    spec_dnm,
    output logic signed [EXPE_W-1:0] exp_eff,
    output logic [EST_W-1:0]        top_frac
);
    logic             sgn;
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    logic             subn, flushed, zero_in, nan_in, inf_in;
    logic [LZ_W-1:0]   lz;

    assign sgn     = operand[WORD_W-1];
    assign ex      = operand[WORD_W-2:FRAC_W];
    assign fr      = operand[FRAC_W-1:0];
    assign subn    = (ex == '0) && (fr != '0);
    assign flushed = flush_en && subn;
    assign zero_in = ((ex == '0) && (fr == '0)) || flushed;
    assign nan_in  = (ex == EXP_ONES) && (fr != '0);
    assign inf_in  = (ex == EXP_ONES) && (fr == '0);

    // leading-one position for the normalising shift
    always_comb begin
        lz = '0;
        for (int i = 0; i < FRAC_W; i++) begin
            if (fr[i]) lz = LZ_W'(FRAC_W - 1 - i);
        end
    end

    always_comb begin
        is_special  = 1'b1;
        spec_result = '0;
        spec_inv    = 1'b0;
        spec_dz     = 1'b0;
        spec_dnm    = flushed;
        if (nan_in) begin
            spec_inv    = ~fr[FRAC_W-1];
            spec_result = dnan_en ? DEF_NAN : (operand | (WORD_W'(1) << (FRAC_W - 1)));
        end else if (zero_in) begin
            spec_dz     = 1'b1;
            spec_result = {sgn, EXP_ONES, {FRAC_W{1'b0}}};
        end else if (sgn) begin
            spec_inv    = 1'b1;
            spec_result = DEF_NAN;
        end else if (inf_in) begin
            spec_result = '0;
        end else begin
            is_special  = 1'b0;
        end
    end

    always_comb begin
        if (ex == '0) begin
            exp_eff  = -$signed({{(EXPE_W-LZ_W){1'b0}}, lz});
            top_frac = EST_W'(({{EST_W{1'b0}}, fr} << (lz + LZ_W'(1))) >> PAD_W);
        end else begin
            exp_eff  = $signed({{(EXPE_W-EXP_W){1'b0}}, ex});
            top_frac = EST_W'(fr >> PAD_W);
        end
    end
endmodule

// File: rtl/rsq_prescale.sv
module rsq_prescale
    import rsq_pkg::*;
(
    input  logic signed [EXPE_W-1:0] exp_eff,
    input  logic [EST_W-1:0]         top_frac,
    output logic [DBL_W-1:0]         a_dbl,
    output logic [EXP_W-1:0]         res_exp
);
    logic [SCALE_W-1:0] a_sc;
    logic [EXPE_W-1:0]  diff;

    // odd exponent: '01' form (128..255); even: '1' form (256..511)
    assign a_sc = exp_eff[0] ? {2'b01, top_frac[EST_W-1:1]}
                             : {1'b1, top_frac};

    always_comb begin
        if (a_sc < SCALE_W'(256))
            a_dbl = {a_sc, 1'b1};
        else
            a_dbl = {a_sc[SCALE_W-1:1], 2'b10};
    end

    assign diff    = EXPE_W'(EXP_OFFSET) - EXPE_W'(exp_eff);
    assign res_exp = EXP_W'(diff >> 1);
endmodule

// File: rtl/rsq_step.sv
module rsq_step
    import rsq_pkg::*;
(
    input  logic [DBL_W-1:0]   a_dbl,
    input  logic [BOUND_W-1:0] bound,
    output logic               go_on
);
    logic [PROD_W-1:0] b1;
    logic [PROD_W-1:0] prod;

    assign b1    = PROD_W'(bound) + PROD_W'(1);
    assign prod  = PROD_W'(a_dbl) * b1 * b1;
    assign go_on = prod < LIMIT;
endmodule

// File: rtl/rsqrt_estimate_unit.sv
module rsqrt_estimate_unit
    import rsq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] operand,
    input  logic        flush_en,
    input  logic        dnan_en,
    output logic        busy,
    output logic        done,
    output logic [31:0] result,
    output logic        flag_invalid,
    output logic        flag_divzero,
    output logic        flag_denorm
);
    rsq_state_e state_q, state_d;

    logic                     is_special, spec_inv, spec_dz, spec_dnm, go_on;
    logic [WORD_W-1:0]        spec_result;
    logic signed [EXPE_W-1:0] exp_eff;
    logic [EST_W-1:0]         top_frac;
    logic [DBL_W-1:0]         a_dbl, a_q;
    logic [EXP_W-1:0]         res_exp, exp_q;
    logic [BOUND_W-1:0]       b_q;
    logic [WORD_W-1:0]        res_q;
    logic                     inv_q, dz_q, dnm_q;

    rsq_classify u_classify (
        .operand    (operand),
        .flush_en   (flush_en),
        .dnan_en    (dnan_en),
        .is_special (is_special),
        .spec_result(spec_result),
        .spec_inv   (spec_inv),
        .spec_dz    (spec_dz),
        .spec_dnm   (spec_dnm),
        .exp_eff    (exp_eff),
        .top_frac   (top_frac)
    );

    rsq_prescale u_prescale (
        .exp_eff (exp_eff),
        .top_frac(top_frac),
        .a_dbl   (a_dbl),
        .res_exp (res_exp)
    );

    rsq_step u_step (
        .a_dbl(a_q),
        .bound(b_q),
        .go_on(go_on)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: resolve, launch, step, settle, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = is_special ? ST_REPORT : ST_SEARCH;
            ST_SEARCH: if (!go_on) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= B_START;
            exp_q <= '0;
            res_q <= '0;
            inv_q <= 1'b0;
            dz_q  <= 1'b0;
            dnm_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start && is_special) begin
                        res_q <= spec_result;
                        inv_q <= spec_inv;
                        dz_q  <= spec_dz;
                        dnm_q <= spec_dnm;
                    end else if (start) begin
                        a_q   <= a_dbl;
                        b_q   <= B_START;
                        exp_q <= res_exp;
                    end
                end
                ST_SEARCH: begin
                    if (go_on) begin
                        b_q <= b_q + BOUND_W'(1);
                    end else begin
                        res_q <= {1'b0, exp_q, EST_W'((b_q + BOUND_W'(1)) >> 1),
                                  {PAD_W{1'b0}}};
                        inv_q <= 1'b0;
                        dz_q  <= 1'b0;
                        dnm_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy         = (state_q != ST_IDLE);
        done         = (state_q == ST_REPORT);
        result       = res_q;
        flag_invalid = inv_q;
        flag_divzero = dz_q;
        flag_denorm  = dnm_q;
    end

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_search_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH) |=> busy);
    a_r10_bound_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH) |-> (b_q >= BOUND_W'(512) && b_q <= BOUND_W'(1022)));
    a_r4_divzero_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_divzero) |-> (result[30:0] == 31'h7F80_0000 && !flag_invalid));
    a_r3_invalid_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_invalid) |-> (result[30:22] == 9'h1FF));
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(flag_invalid) && $stable(flag_divzero)));
endmodule

// File: tb/test_rsqrt_estimate_unit.sv
`timescale 1ns/1ps
module test_rsqrt_estimate_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic        flush_en = 1'b0;
    logic        dnan_en = 1'b0;
    logic        busy, done, flag_invalid, flag_divzero, flag_denorm;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    rsqrt_estimate_unit i_rsqrt_estimate_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .flush_en(flush_en), .dnan_en(dnan_en), .busy(busy), .done(done),
        .result(result), .flag_invalid(flag_invalid),
        .flag_divzero(flag_divzero), .flag_denorm(flag_denorm)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: act %0d cycles exp fewer", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act %0h exp %0h", req, act, exp);
        end
    endtask

    // behavioural model derived from R2..R11
    task automatic ref_model(input logic [31:0] op, input bit fz, input bit dn,
                             output logic [31:0] r, output logic [2:0] fl, output int lat);
        bit     sg = op[31];
        int     ex = int'(op[30:23]);
        longint fr = longint'(op[22:0]);
        bit     inv = 0, dz = 0, dnm = 0;
        lat = 1;
        if (fz && ex == 0 && fr != 0) begin dnm = 1; fr = 0; end
        if (ex == 255 && fr != 0) begin
            inv = (op[22] == 1'b0);
            r   = dn ? 32'h7FC00000 : (op | 32'h00400000);
        end else if (ex == 0 && fr == 0) begin
            dz = 1;
            r  = sg ? 32'hFF800000 : 32'h7F800000;
        end else if (sg) begin
            inv = 1;
            r   = 32'h7FC00000;
        end else if (ex == 255) begin
            r = 32'h0;
        end else begin
            longint a, a2, b;
            int est, rexp;
            if (ex == 0) begin
                while (fr[22] == 1'b0) begin fr = fr << 1; ex = ex - 1; end
                fr = (fr << 1) & 64'h7FFFFF;
            end
            if (ex % 2 != 0) a = 128 + (fr >> 16);
            else             a = 256 + (fr >> 15);
            if (a < 256) a2 = 2 * a + 1;
            else         a2 = ((a / 2) * 2 + 1) * 2;
            b = 512;
            while (a2 * (b + 1) * (b + 1) < 268435456) b++;
            est  = int'((b + 1) / 2);
            rexp = (380 - ex) / 2;
            r    = {1'b0, rexp[7:0], est[7:0], 15'b0};
            lat  = int'(b - 512) + 2;
        end
        fl = {inv, dz, dnm};
    endtask

    task automatic run_op(input logic [31:0] op, input bit fz, input bit dn,
                          input bit disturb, input string req);
        logic [31:0] er, gr;
        logic [2:0]  ef, gf;
        int          lat, seen;
        bit          tim_ok = 1;
        ref_model(op, fz, dn, er, ef, lat);
        seen = -1;
        gr = '0;
        gf = '0;
        @(negedge clk);
        operand = op; flush_en = fz; dnan_en = dn; start = 1'b1;
        for (int i = 1; i <= lat + 3; i++) begin
            @(negedge clk);
            if (i == 1) start = 1'b0;
            if (disturb && i == 2) begin start = 1'b1; operand = 32'h40800000; end
            if (disturb && i == 3) start = 1'b0;
            if (done && seen < 0) seen = i;
            if (done !== (i == lat) || busy !== (i <= lat)) tim_ok = 0;
            if (i == lat) begin
                gr = result;
                gf = {flag_invalid, flag_divzero, flag_denorm};
            end
        end
        check(tim_ok, "R2 latency/handshake", seen, lat);
        check(gr === er, {req, " result"}, gr, er);
        check(gf === ef, {req, " flags"}, gf, ef);
        check(result === er && {flag_invalid, flag_divzero, flag_denorm} === ef,
              "R12 hold after done", result, er);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy === 1'b0 && done === 1'b0, "R1 reset busy/done", {busy, done}, 0);
        check(result === 32'h0 && {flag_invalid, flag_divzero, flag_denorm} === 3'b0,
              "R1 reset result/flags", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && result === 32'h0, "R1 after reset", result, 0);

        // R9/R10/R11 normal operands, both parity forms, both search ends
        run_op(32'h3F800000, 0, 0, 0, "R9 R10 R11 one");
        run_op(32'h40000000, 0, 0, 0, "R9 R11 two");
        run_op(32'h40800000, 0, 0, 0, "R11 four");
        run_op(32'h3FC00000, 0, 0, 0, "R10 one-and-half");
        run_op(32'h4123ABCD, 0, 0, 0, "R10 mixed fraction");
        run_op(32'h407F8000, 0, 0, 0, "R10 shortest search");
        run_op(32'h7F7FFFFF, 0, 0, 0, "R11 max normal");
        run_op(32'h00800000, 0, 0, 0, "R11 min normal");
        // R8 denormals without flush
        run_op(32'h00000001, 0, 0, 0, "R8 smallest denormal");
        run_op(32'h00400000, 0, 0, 0, "R8 top-bit denormal");
        run_op(32'h0005A5A5, 0, 0, 0, "R8 mid denormal");
        // R7 flush
        run_op(32'h00000001, 1, 0, 0, "R7 flushed denormal");
        run_op(32'h80400000, 1, 0, 0, "R7 flushed negative denormal");
        run_op(32'h3F800000, 1, 0, 0, "R7 flush on normal");
        // R4 zeros
        run_op(32'h00000000, 0, 0, 0, "R4 positive zero");
        run_op(32'h80000000, 0, 0, 0, "R4 negative zero");
        // R5 negatives
        run_op(32'hBF800000, 0, 0, 0, "R5 negative one");
        run_op(32'hFF800000, 0, 0, 0, "R5 negative infinity");
        run_op(32'h80000001, 0, 0, 0, "R5 negative denormal");
        // R6 positive infinity
        run_op(32'h7F800000, 0, 0, 0, "R6 positive infinity");
        // R3 NaNs
        run_op(32'h7F800001, 0, 0, 0, "R3 signalling NaN");
        run_op(32'hFFC12345, 0, 0, 0, "R3 quiet NaN");
        run_op(32'h7FC12345, 0, 1, 0, "R3 quiet NaN default mode");
        run_op(32'hFF812345, 0, 1, 0, "R3 signalling NaN default mode");
        // R2 start while busy is dropped
        run_op(32'h3F800000, 0, 0, 1, "R2 start during search");
        run_op(32'h41200000, 0, 0, 1, "R2 start during search b");

        repeat (4) @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R2 idle at end", {busy, done}, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule